// File: doc/BRIEF.md
# Precise Exception Controller for a Five-Stage Pipeline

This block steers exceptions in an in-order pipeline with fetch, decode, execute, memory and writeback stages. Three stages raise their own fault flags: decode flags an undefined opcode, execute flags an arithmetic overflow, and memory flags an access fault. Each flag comes with the PC+4 of the instruction that stage holds. An asynchronous interrupt line also comes in from outside the core. Within one cycle the controller picks the fault of the oldest instruction. It flushes that instruction and every younger one into bubbles, and it blocks the faulting instruction's register write. It also pulses a redirect that sends fetch to the fixed handler address.

On the clock edge that ends the redirect cycle, the controller loads the return address (PC+4 of the instruction being serviced) and a two-bit cause code into its own registers. Interrupts pass through a registered enable bit. That bit is cleared whenever any exception is taken and is set again by a one-cycle request. An interrupt is serviced only in a cycle with no synchronous fault, and it is charged to the instruction sitting in decode. Everything older than decode finishes normally.

Top module: `exc_ctrl`

## Requirements
- R1: After reset, epc and cause read 0, int_en reads 0, and redirect, flush and wr_block are low while no fault input is raised.
- R2: When more than one stage reports a fault in the same cycle, the oldest instruction is serviced. The memory-stage fault beats the execute-stage overflow, which beats the decode-stage undefined opcode.
- R3: On the edge that ends a redirect cycle, epc takes the PC+4 of the serviced instruction. cause takes 0 for an undefined opcode, 1 for overflow, 2 for a memory access fault and 3 for an interrupt.
- R4: In every redirect cycle, redirect_pc equals 0x80000180.
- R5: flush bit 0 is fetch, bit 1 is decode, bit 2 is execute and bit 3 is memory. In a redirect cycle the serviced stage and every younger stage are flushed, and older stages are not. The patterns are 1111 for memory, 0111 for execute, and 0011 for decode or an interrupt.
- R6: wr_block is high in the redirect cycle of an execute overflow or a memory fault, so the faulting instruction's destination register keeps its old value. It is low otherwise.
- R7: An interrupt is taken only when int_en is 1 and no synchronous fault is raised. It records the decode stage's PC+4 with cause 3, and it leaves the execute and memory instructions running.
- R8: Taking any exception clears int_en. A pulse on int_en_set sets it when no exception is taken in that cycle. While int_en is 0, irq causes no redirect and leaves epc and cause unchanged.
- R9: redirect and flush last exactly one cycle. In the cycle right after a redirect no fault or interrupt is accepted, even if the inputs are still raised.
- R10: epc and cause hold their values across every cycle without a redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_illegal | input | 1 | Decode stage holds an undefined opcode |
| id_pc4 | input | XLEN | PC+4 of the decode-stage instruction |
| ex_ovf | input | 1 | Execute stage produced an arithmetic overflow |
| ex_pc4 | input | XLEN | PC+4 of the execute-stage instruction |
| mem_fault | input | 1 | Memory stage hit an access fault |
| mem_pc4 | input | XLEN | PC+4 of the memory-stage instruction |
| irq | input | 1 | External interrupt request |
| int_en_set | input | 1 | One-cycle request to enable interrupts |
| redirect | output | 1 | Pulse: fetch must load redirect_pc |
| redirect_pc | output | XLEN | Handler entry address |
| flush | output | 4 | Per-stage bubble pulse {mem, ex, id, if} |
| wr_block | output | 1 | Block the faulting instruction's register write |
| epc | output | XLEN | Saved return address (PC+4) |
| cause | output | 2 | Saved exception cause code |
| int_en | output | 1 | Interrupt enable state |

## Verification
The bench sweeps every combination of the three fault flags and the interrupt line, once with interrupts enabled and once with them disabled. Each case gets its own distinct PC+4 values, so a wrong stage choice shows up as a wrong epc.

Several mistakes are aimed at directly:
- A priority inverted toward the younger instruction would save the execute address when the memory stage also faulted.
- An off-by-one flush mask would kill the completing memory instruction on an overflow.
- A missing enable check would take the interrupt while it is masked.

Each case keeps its inputs raised for a second cycle. A controller without the post-redirect holdoff would then pulse twice and overwrite epc.

// File: rtl/exc_ctrl.sv
module exc_ctrl #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] VECTOR = XLEN'(32'h8000_0180)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            id_illegal,
  input  logic [XLEN-1:0] id_pc4,
  input  logic            ex_ovf,
  input  logic [XLEN-1:0] ex_pc4,
  input  logic            mem_fault,
  input  logic [XLEN-1:0] mem_pc4,
  input  logic            irq,
  input  logic            int_en_set,
  output logic            redirect,
  output logic [XLEN-1:0] redirect_pc,
  output logic [3:0]      flush,
  output logic            wr_block,
  output logic [XLEN-1:0] epc,
  output logic [1:0]      cause,
  output logic            int_en
);

  logic hold;
  logic sync_any;
  logic take_mem, take_ex, take_id, take_irq;
  logic [XLEN-1:0] nxt_epc;
  logic [1:0] nxt_cause;

  assign sync_any = mem_fault | ex_ovf | id_illegal;
  assign take_mem = ~hold & mem_fault;
  assign take_ex  = ~hold & ~mem_fault & ex_ovf;
  assign take_id  = ~hold & ~mem_fault & ~ex_ovf & id_illegal;
  assign take_irq = ~hold & ~sync_any & irq & int_en;

  assign redirect    = take_mem | take_ex | take_id | take_irq;
  assign redirect_pc = VECTOR;
  assign wr_block    = take_mem | take_ex;
  assign flush       = {take_mem, take_mem | take_ex, redirect, redirect};

  always_comb begin
    nxt_epc   = id_pc4;
    nxt_cause = 2'd3;
    if (take_mem) begin
      nxt_epc   = mem_pc4;
      nxt_cause = 2'd2;
    end else if (take_ex) begin
      nxt_epc   = ex_pc4;
      nxt_cause = 2'd1;
    end else if (take_id) begin
      nxt_epc   = id_pc4;
      nxt_cause = 2'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold   <= 1'b0;
      epc    <= '0;
      cause  <= 2'd0;
      int_en <= 1'b0;
    end else begin
      hold <= redirect;
      if (redirect) begin
        epc    <= nxt_epc;
        cause  <= nxt_cause;
        int_en <= 1'b0;
      end else if (int_en_set) begin
        int_en <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] VECTOR = XLEN'(32'h8000_0180)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            id_illegal,
  input logic            ex_ovf,
  input logic [XLEN-1:0] ex_pc4,
  input logic            mem_fault,
  input logic [XLEN-1:0] mem_pc4,
  input logic            irq,
  input logic            redirect,
  input logic [XLEN-1:0] redirect_pc,
  input logic [3:0]      flush,
  input logic            wr_block,
  input logic [XLEN-1:0] epc,
  input logic [1:0]      cause,
  input logic            int_en
);

  assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !redirect && flush == 4'b0000);

  assert_mem_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    redirect && mem_fault |-> flush == 4'b1111 && wr_block);

  assert_mem_epc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    redirect && mem_fault |=> epc == $past(mem_pc4) && cause == 2'd2);

  assert_ovf_epc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    redirect && ex_ovf && !mem_fault |=> epc == $past(ex_pc4) && cause == 2'd1);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    redirect && ex_ovf && !mem_fault |-> wr_block && flush == 4'b0111);

  assert_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> redirect_pc == VECTOR && flush[1:0] == 2'b11);

  assert_irq_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !int_en && !(mem_fault || ex_ovf || id_illegal) |-> !redirect);

  assert_en_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !int_en);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |=> $stable(epc) && $stable(cause));

endmodule

bind exc_ctrl exc_ctrl_chk #(.XLEN(XLEN), .VECTOR(VECTOR)) u_chk (
  .clk(clk), .rst_n(rst_n), .id_illegal(id_illegal), .ex_ovf(ex_ovf),
  .ex_pc4(ex_pc4), .mem_fault(mem_fault), .mem_pc4(mem_pc4), .irq(irq),
  .redirect(redirect), .redirect_pc(redirect_pc), .flush(flush),
  .wr_block(wr_block), .epc(epc), .cause(cause), .int_en(int_en)
);

// File: tb/exc_ctrl_test.sv
module exc_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        id_illegal = 1'b0, ex_ovf = 1'b0, mem_fault = 1'b0, irq = 1'b0, int_en_set = 1'b0;
  logic [31:0] id_pc4 = '0, ex_pc4 = '0, mem_pc4 = '0;
  logic        redirect, wr_block, int_en;
  logic [31:0] redirect_pc, epc;
  logic [3:0]  flush;
  logic [1:0]  cause;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  exc_ctrl uut (
    .clk(clk), .rst_n(rst_n), .id_illegal(id_illegal), .id_pc4(id_pc4),
    .ex_ovf(ex_ovf), .ex_pc4(ex_pc4), .mem_fault(mem_fault), .mem_pc4(mem_pc4),
    .irq(irq), .int_en_set(int_en_set), .redirect(redirect),
    .redirect_pc(redirect_pc), .flush(flush), .wr_block(wr_block),
    .epc(epc), .cause(cause), .int_en(int_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    {id_illegal, ex_ovf, mem_fault, irq, int_en_set} = '0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    #1;
    chk("R1 epc", epc, 0);
    chk("R1 cause", 32'(cause), 0);
    chk("R1 int_en", 32'(int_en), 0);
    chk("R1 redirect", 32'(redirect), 0);
    chk("R1 flush", 32'(flush), 0);
    chk("R1 wr_block", 32'(wr_block), 0);

    for (int en = 0; en < 2; en++) begin
      for (int k = 0; k < 16; k++) begin
        logic m, e, d, q, take;
        logic [3:0]  ef;
        logic [1:0]  ec;
        logic [31:0] ep;
        m = k[3]; e = k[2]; d = k[1]; q = k[0];
        do_reset();
        if (en == 1) begin
          int_en_set = 1'b1;
          @(negedge clk);
          int_en_set = 1'b0;
          #1 chk("R8 enable set", 32'(int_en), 1);
        end
        mem_pc4 = 32'h1000_0010 + 32'(k * 256 + en * 4096);
        ex_pc4  = mem_pc4 - 32'h4;
        id_pc4  = mem_pc4 - 32'h8;
        take = m | e | d | (q & (en == 1));
        ef = m ? 4'b1111 : e ? 4'b0111 : (d | take) ? 4'b0011 : 4'b0000;
        ec = m ? 2'd2 : e ? 2'd1 : d ? 2'd0 : 2'd3;
        ep = m ? mem_pc4 : e ? ex_pc4 : id_pc4;
        @(negedge clk);
        mem_fault = m; ex_ovf = e; id_illegal = d; irq = q;
        #2;
        chk("R2 R7 R8 redirect", 32'(redirect), 32'(take));
        chk("R5 flush", 32'(flush), 32'(ef));
        chk("R6 wr_block", 32'(wr_block), 32'(m | e));
        if (take) chk("R4 vector", redirect_pc, 32'h8000_0180);
        @(negedge clk);
        if (!take) begin
          {mem_fault, ex_ovf, id_illegal, irq} = '0;
        end
        #1;
        if (take) begin
          chk("R2 R3 epc", epc, ep);
          chk("R3 cause", 32'(cause), 32'(ec));
          chk("R8 enable cleared", 32'(int_en), 0);
          chk("R9 no second redirect", 32'(redirect), 0);
          chk("R9 no second flush", 32'(flush), 0);
        end else begin
          chk("R8 R10 epc held", epc, 0);
          chk("R10 cause held", 32'(cause), 0);
        end
        @(negedge clk);
        {mem_fault, ex_ovf, id_illegal, irq} = '0;
        #1;
        chk("R9 R10 epc stable", epc, take ? ep : 32'h0);
        chk("R10 cause stable", 32'(cause), take ? 32'(ec) : 32'h0);
      end
    end

    do_reset();
    int_en_set = 1'b1;
    irq = 1'b1;
    id_pc4 = 32'h0000_4444;
    @(negedge clk);
    int_en_set = 1'b0;
    #2 chk("R7 irq after enable", 32'(redirect), 1);
    chk("R7 irq flush", 32'(flush), 32'h3);
    @(negedge clk);
    irq = 1'b0;
    #1 chk("R7 irq epc", epc, 32'h0000_4444);
    chk("R7 irq cause", 32'(cause), 3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule